// File: doc/BRIEF.md
# Error-Tolerant Manchester Wake Correlator

This block looks for a fixed wake pattern in sliced binary data. Each receive channel has its own correlator. The input is a level that an analog slicer produces, and the block samples it on every clock of a 32.768 kHz timebase. Each channel splits that level into half-bits of 12 clocks and realigns to every data edge. It shifts the half-bits into a 16-entry history, and a channel raises a one-cycle `match` pulse when the history holds the wake pattern.

A match needs every one half-bit of the pattern to be present. A selectable number of zero half-bits may read as ones. In double mode a channel arms a window after a first match, and it pulses only if a second copy fills exactly the next 16 half-bits. Each copy is scored against the error limit on its own.

A channel that sees neither a data edge nor a high level for 108 clocks enters standby and clears its state. It resumes on the first clock that shows data again. `din` is a free-running sampled level rather than a packet stream. It carries no valid/ready handshake, because a slicer output cannot be stalled and back-pressure has no meaning for it. The data is consumed on every enabled clock.

Top module: `wake_correlator`

## Requirements
- R1: A half-bit lasts 12 clocks, and timing restarts on every change of the registered input. The half-bit value is the majority of the samples at positions 5, 6 and 7 of its window, counting from 0.
- R2: The wake pattern is 1001011001101001 (16'h9669), earliest half-bit first. Let the last half-bit first be registered at edge E. A match is then high for exactly the one cycle after edge E+13 and low in the cycle before.
- R3: A history that has a zero where the pattern has a one never matches, whatever the tolerance.
- R4: `tol_code` selects how many pattern-zero half-bits may read as one: 2'b00 allows 3, 2'b10 allows 2, 2'b01 allows 1, 2'b11 allows 0.
- R5: With `dbl_mode` high, a channel pulses only at the end of a second copy. Each copy must meet the error limit by itself.
- R6: In double mode the second copy must start on the half-bit right after the first copy. One extra half-bit between the copies gives no pulse.
- R7: With `corr_en` low, all channel state is held cleared, `match` stays low and `standby` stays low.
- R8: `standby` is low out of reset. After `din` goes low, `standby` rises on edge 109 counted from the edge that registers the low, and it stays high while the input stays quiet. It falls on the second edge after `din` goes high.
- R9: Channels are independent. Each channel's pulse depends only on its own `din` bit.
- R10: An alternating preamble, with or without more alternating half-bits after it, never produces a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| corr_en | input | 1 | Correlator enable; low holds every channel cleared |
| dbl_mode | input | 1 | High requires two back-to-back copies of the pattern |
| tol_code | input | 2 | Zero half-bit error allowance code (see R4) |
| din | input | NCH | Sliced data level, one bit per channel |
| match | output | NCH | One-cycle wake pulse per channel |
| standby | output | NCH | High while a channel has stopped for inactivity |

## Verification
An input registered at edge E yields a half-bit at edge E+12. The match register follows one edge later, so a match is high only in the cycle after E+13. The bench drives inputs on falling edges and holds each half-bit for 12 of them. It checks `match` is low at the 13th falling edge after the final half-bit was driven and has its expected value at the 14th. The standby rise is checked at falling edges 109 and 110 after the input drops, and the fall at the first and second falling edges after it rises. A running pulse tally per channel then confirms that no extra pulse appeared anywhere in the case.

// File: rtl/wk_pkg.sv
package wk_pkg;

  // Error allowance codes for zero half-bits
  typedef enum logic [1:0] {
    TOL_THREE = 2'b00,
    TOL_ONE   = 2'b01,
    TOL_TWO   = 2'b10,
    TOL_NONE  = 2'b11
  } tol_e;

  function automatic int tol_limit(input logic [1:0] code);
    case (tol_e'(code))
      TOL_THREE: return 3;
      TOL_TWO:   return 2;
      TOL_ONE:   return 1;
      default:   return 0;
    endcase
  endfunction

endpackage

// File: rtl/wk_hb_sampler.sv
module wk_hb_sampler #(
  parameter int HALF = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic bit_i,
  input  logic edge_i,
  output logic hb_vld_o,
  output logic hb_bit_o
);
  localparam int CW  = $clog2(HALF);
  localparam int MID = HALF / 2;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);
  localparam logic [CW-1:0] VA   = CW'(MID - 1);
  localparam logic [CW-1:0] VB   = CW'(MID);
  localparam logic [CW-1:0] VC   = CW'(MID + 1);

  logic [CW-1:0] cnt, pos;
  logic [2:0]    votes;
  logic          maj;

  always_comb begin
    if (edge_i || cnt == LAST) pos = '0;
    else                       pos = cnt + 1'b1;
    maj = (votes[0] & votes[1]) | (votes[0] & votes[2]) | (votes[1] & votes[2]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      votes    <= '0;
      hb_vld_o <= 1'b0;
      hb_bit_o <= 1'b0;
    end else if (clr) begin
      cnt      <= '0;
      votes    <= '0;
      hb_vld_o <= 1'b0;
      hb_bit_o <= 1'b0;
    end else begin
      cnt <= pos;
      if (pos == VA) votes[0] <= bit_i;
      if (pos == VB) votes[1] <= bit_i;
      if (pos == VC) votes[2] <= bit_i;
      hb_vld_o <= (pos == LAST);
      if (pos == LAST) hb_bit_o <= maj;
    end
  end

  AST_HB_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    hb_vld_o |=> !hb_vld_o); // R1

endmodule

// File: rtl/wk_idle_timer.sv
module wk_idle_timer #(
  parameter int LIMIT = 108
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic activity_i,
  output logic awake_o,
  output logic sleep_o
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] TOP = CW'(LIMIT);

  logic [CW-1:0] quiet;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               quiet <= '0;
    else if (!en_i)           quiet <= '0;
    else if (activity_i)      quiet <= '0;
    else if (quiet != TOP)    quiet <= quiet + 1'b1;
  end

  assign sleep_o = (quiet == TOP);
  assign awake_o = activity_i || !sleep_o;

  AST_WAKE_ON_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && activity_i) |=> !sleep_o); // R8
  AST_STAY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sleep_o && !activity_i) |=> sleep_o); // R8

endmodule

// File: rtl/wk_matcher.sv
module wk_matcher #(
  parameter int            HB  = 16,
  parameter logic [HB-1:0] PAT = 16'h9669
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       dbl_i,
  input  logic [1:0] tol_i,
  input  logic       hb_vld_i,
  input  logic       hb_bit_i,
  output logic       match_o
);
  import wk_pkg::*;

  localparam int WCW = $clog2(HB);
  localparam logic [WCW-1:0] WLAST = WCW'(HB - 1);

  logic [HB-1:0]  hist, hist_nx;
  logic           ones_ok, single;
  int             zero_err, limit;
  logic           armed;
  logic [WCW-1:0] win;

  always_comb begin
    hist_nx  = {hist[HB-2:0], hb_bit_i};
    ones_ok  = ((~hist_nx) & PAT) == '0;
    zero_err = $countones(hist_nx & ~PAT);
    limit    = tol_limit(tol_i);
    single   = ones_ok && (zero_err <= limit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist    <= '0;
      armed   <= 1'b0;
      win     <= '0;
      match_o <= 1'b0;
    end else if (clr) begin
      hist    <= '0;
      armed   <= 1'b0;
      win     <= '0;
      match_o <= 1'b0;
    end else begin
      match_o <= 1'b0;
      if (hb_vld_i) begin
        hist <= hist_nx;
        if (!dbl_i) begin
          match_o <= single;
          armed   <= 1'b0;
          win     <= '0;
        end else if (!armed) begin
          armed <= single;
          win   <= '0;
        end else if (win == WLAST) begin
          match_o <= single;
          armed   <= 1'b0;
          win     <= '0;
        end else begin
          win <= win + 1'b1;
        end
      end
    end
  end

  AST_PULSE_FROM_HB: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> $past(hb_vld_i)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o); // R2
  AST_DBL_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && $past(dbl_i)) |-> $past(armed)); // R5

endmodule

// File: rtl/wk_channel.sv
module wk_channel #(
  parameter int            HALF = 12,
  parameter int            HB   = 16,
  parameter logic [HB-1:0] PAT  = 16'h9669,
  parameter int            IDLE = 108
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic       dbl_i,
  input  logic [1:0] tol_i,
  input  logic       din_i,
  output logic       match_o,
  output logic       sleep_o
);
  logic s1, s2, data_edge, activity, awake, clr;
  logic hb_vld, hb_bit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else if (!en_i) begin
      s1 <= 1'b0;
      s2 <= 1'b0;
    end else begin
      s1 <= din_i;
      s2 <= s1;
    end
  end

  assign data_edge = s1 ^ s2;
  assign activity  = data_edge | s1;
  assign clr       = !en_i || !awake;

  wk_idle_timer #(.LIMIT(IDLE)) u_idle (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .activity_i(activity),
    .awake_o(awake), .sleep_o(sleep_o)
  );

  wk_hb_sampler #(.HALF(HALF)) u_samp (
    .clk(clk), .rst_n(rst_n), .clr(clr), .bit_i(s1), .edge_i(data_edge),
    .hb_vld_o(hb_vld), .hb_bit_o(hb_bit)
  );

  wk_matcher #(.HB(HB), .PAT(PAT)) u_match (
    .clk(clk), .rst_n(rst_n), .clr(clr), .dbl_i(dbl_i), .tol_i(tol_i),
    .hb_vld_i(hb_vld), .hb_bit_i(hb_bit), .match_o(match_o)
  );

endmodule

// File: rtl/wake_correlator.sv
module wake_correlator #(
  parameter int            NCH  = 3,
  parameter int            HALF = 12,
  parameter int            HB   = 16,
  parameter logic [HB-1:0] PAT  = 16'h9669,
  parameter int            IDLE = 108
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           corr_en,
  input  logic           dbl_mode,
  input  logic [1:0]     tol_code,
  input  logic [NCH-1:0] din,
  output logic [NCH-1:0] match,
  output logic [NCH-1:0] standby
);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    wk_channel #(.HALF(HALF), .HB(HB), .PAT(PAT), .IDLE(IDLE)) u_ch (
      .clk(clk), .rst_n(rst_n), .en_i(corr_en), .dbl_i(dbl_mode),
      .tol_i(tol_code), .din_i(din[c]), .match_o(match[c]), .sleep_o(standby[c])
    );
  end

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !corr_en |=> (match == '0 && standby == '0)); // R7

endmodule

// File: tb/wake_correlator_test.sv
module wake_correlator_test;
  localparam int NCH = 3;
  localparam int HALF = 12;
  localparam logic [15:0] PATW = 16'h9669;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic corr_en = 1'b1;
  logic dbl_mode = 1'b0;
  logic [1:0] tol_code = 2'b01;
  logic [NCH-1:0] din = '0;
  logic [NCH-1:0] match;
  logic [NCH-1:0] standby;

  int checks = 0;
  int fails = 0;
  int total [NCH];

  always #10 clk = ~clk;

  wake_correlator #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .corr_en(corr_en), .dbl_mode(dbl_mode),
    .tol_code(tol_code), .din(din), .match(match), .standby(standby)
  );

  always @(negedge clk) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) total[c] = 0;
    end else begin
      for (int c = 0; c < NCH; c++) if (match[c]) total[c] = total[c] + 1;
    end
  end

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int lim(input logic [1:0] code);
    case (code)
      2'b00: return 3;
      2'b10: return 2;
      2'b01: return 1;
      default: return 0;
    endcase
  endfunction

  // pattern with its first k zero half-bits (earliest first) turned into ones
  function automatic logic [15:0] err_word(input int k);
    logic [15:0] w = PATW;
    int n = 0;
    for (int b = 15; b >= 0; b--) begin
      if (!PATW[b] && n < k) begin
        w[b] = 1'b1;
        n++;
      end
    end
    return w;
  endfunction

  task automatic send_hb(input logic [NCH-1:0] v);
    din = v;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic send_word(input logic [NCH-1:0][15:0] w);
    logic [NCH-1:0] v;
    for (int b = 15; b >= 0; b--) begin
      for (int c = 0; c < NCH; c++) v[c] = w[c][b];
      send_hb(v);
    end
  endtask

  task automatic run_case(input logic en, input logic dbl, input logic [1:0] code,
                          input logic [NCH-1:0][15:0] w1, input logic use2, input logic gap,
                          input logic [NCH-1:0][15:0] w2, input logic [NCH-1:0] expv,
                          input string req);
    int base [NCH];
    corr_en = en;
    dbl_mode = dbl;
    tol_code = code;
    for (int c = 0; c < NCH; c++) base[c] = total[c];
    // first preamble half-bit, with wake timing checks
    din = '1;
    @(negedge clk);
    if (en) check(standby == '1, "R8 wake edge1", int'(standby), (1 << NCH) - 1);
    @(negedge clk);
    check(standby == '0, "R8 wake edge2", int'(standby), 0);
    repeat (HALF - 2) @(negedge clk);
    for (int i = 1; i < 8; i++) send_hb((i % 2) ? '0 : '1);
    send_word(w1);
    if (gap) send_hb('0);
    if (use2) send_word(w2);
    @(negedge clk);
    check(match == '0, {req, " R2 early"}, int'(match), 0);
    @(negedge clk);
    check(match == expv, {req, " R2 due"}, int'(match), int'(expv));
    din = '0;
    repeat (109) @(negedge clk);
    check(standby == '0, "R8 before limit", int'(standby), 0);
    @(negedge clk);
    check(standby == (en ? '1 : '0), "R8 at limit", int'(standby), en ? (1 << NCH) - 1 : 0);
    repeat (10) @(negedge clk);
    for (int c = 0; c < NCH; c++)
      check(total[c] - base[c] == int'(expv[c]), {req, " R9 pulse count"},
            total[c] - base[c], int'(expv[c]));
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [NCH-1:0][15:0] w1;
    logic [NCH-1:0][15:0] w2;
    logic [NCH-1:0] e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(match == '0, "R2 reset match", int'(match), 0);
    check(standby == '0, "R8 reset standby", int'(standby), 0);
    repeat (115) @(negedge clk);
    check(standby == '1, "R8 idle after reset", int'(standby), (1 << NCH) - 1);

    // R4 / R1 / R9: single mode sweep over tolerance and error count
    for (int code = 0; code < 4; code++) begin
      for (int k = 0; k < 5; k++) begin
        for (int c = 0; c < NCH; c++) begin
          w1[c] = err_word((k + c) % 5);
          e[c] = ((k + c) % 5) <= lim(2'(code));
        end
        run_case(1'b1, 1'b0, 2'(code), w1, 1'b0, 1'b0, w1, e, "R4 R1 single");
      end
    end

    // R3: a missing one never matches, even at the loosest tolerance
    w1[0] = PATW;
    w1[1] = PATW & ~16'h1000;
    w1[2] = PATW & ~16'h0200;
    run_case(1'b1, 1'b0, 2'b00, w1, 1'b0, 1'b0, w1, 3'b001, "R3 ones");

    // R5: double mode, each copy scored on its own
    for (int ci = 0; ci < 2; ci++) begin
      for (int k1 = 0; k1 < 3; k1++) begin
        for (int k2 = 0; k2 < 3; k2++) begin
          logic [1:0] cd = (ci == 0) ? 2'b10 : 2'b01;
          for (int c = 0; c < NCH; c++) begin
            w1[c] = err_word(k1);
            w2[c] = err_word((k2 + c) % 3);
            e[c] = (k1 <= lim(cd)) && (((k2 + c) % 3) <= lim(cd));
          end
          run_case(1'b1, 1'b1, cd, w1, 1'b1, 1'b0, w2, e, "R5 double");
        end
      end
    end

    // R6: one extra half-bit between copies breaks the sequence
    for (int c = 0; c < NCH; c++) begin
      w1[c] = PATW;
      w2[c] = PATW;
    end
    run_case(1'b1, 1'b1, 2'b01, w1, 1'b1, 1'b1, w2, 3'b000, "R6 gap");
    run_case(1'b1, 1'b1, 2'b01, w1, 1'b1, 1'b0, w2, 3'b111, "R6 back to back");

    // R10: alternating half-bits only
    for (int c = 0; c < NCH; c++) begin
      w1[c] = 16'h5555;
      w2[c] = 16'h5555;
    end
    run_case(1'b1, 1'b0, 2'b00, w1, 1'b1, 1'b0, w2, 3'b000, "R10 preamble");

    // R7: disabled correlator ignores a clean pattern
    for (int c = 0; c < NCH; c++) w1[c] = PATW;
    run_case(1'b0, 1'b0, 2'b00, w1, 1'b0, 1'b0, w1, 3'b000, "R7 disabled");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule